// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a free-running up-counter with a compare register. The count width is a parameter and is 16 bits by default. The counter advances on a one-cycle enable from an internal prescaler, which divides the system clock by 4 or by 64. The counter is never cleared by a compare match. Each time it steps onto the compare value, the block raises a one-cycle interrupt request. It can also invert an output data bit that drives a timer pin. When the counter rolls over from all-ones to zero, it sets a sticky overflow flag.

Software uses a simple register port: address, write strobe and write data, with a combinational read mux. One 8-bit control register sets the count clock, the inversion enable, the pin enable and a capture edge field. The same register reports the output data bit and the overflow flag. A small run-mode state machine decodes the control fields into three states:

- ST_HALT: the counter holds.
- ST_FAST: the counter counts at clock/4.
- ST_SLOW: the counter counts at clock/64.

The state machine moves between these states as follows:

- ST_HALT to ST_FAST, when the fields become valid with clock code 00.
- ST_HALT to ST_SLOW, when the fields become valid with clock code 01.
- ST_FAST to ST_SLOW and ST_SLOW to ST_FAST, on a change of clock code.
- Any state to ST_HALT, when the fields become invalid.

Every state change restarts the prescaler. An external mask input blocks the interrupt output. Software raises the mask while it rewrites the compare value.

Top module: `cmp_interval_timer`

## Requirements
- R1: On synchronous active-high reset the control register, the compare register and the counter are 0. The irq, tmr_out and overflow outputs are 0. The state is ST_HALT, because a capture field of 00 is invalid.
- R2: The control register layout is: bit 7 output data, bit 6 overflow, bits 5:4 capture edge, bit 3 inversion enable, bits 2:1 clock select, bit 0 pin enable. Clock code 00 advances the counter once every 4 clocks. Code 01 advances it once every 64 clocks. A compare value C is reached, and irq rises, 1+DIV*C clocks after the clock edge that writes a valid control value.
- R3: Clock codes 10 and 11 select ST_HALT. The counter holds its value and no interrupt occurs.
- R4: A capture edge field of 00 also selects ST_HALT. Any non-zero capture field is accepted, and no capture function exists.
- R5: irq is high for exactly one cycle, starting at the edge where the counter steps onto the compare value. The counter keeps counting. The next match follows 2^CNT_W*DIV clocks later. A compare value of 0 matches on the roll-over.
- R6: A counter that stalls at the compare value does not fire again. Writing the compare register to the held count does not fire either.
- R7: With inversion enabled (bit 3), each match inverts the output data bit at the edge where irq rises. With inversion disabled, the bit is unchanged.
- R8: tmr_out equals the output data bit when the pin enable (bit 0) is 1, and is 0 otherwise.
- R9: The overflow flag (bit 6, output ovf_flag) is set when the counter rolls over and stays set. Writing 0 to bit 6 clears it. Writing 1 to bit 6 has no effect.
- R10: irq_mask=1 forces irq to 0. It does not affect counting or output inversion.
- R11: Address 0 selects the control register, address 1 the compare register and address 2 the counter, which is read only. Address 3 reads 0. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data; the control register uses bits 7:0 |
| rd_data | output | CNT_W | Read data of the selected register |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| irq | output | 1 | One-cycle compare-match interrupt request |
| tmr_out | output | 1 | Timer output pin |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Assertions check the following on every cycle:

- The counter only ever steps by one.
- The counter holds while in ST_HALT.
- The prescaler enable never lasts two cycles.
- Each interrupt leaves the counter equal to the compare value it matched.
- An enabled match always inverts the output data bit.
- The overflow flag never drops without a clearing write.

Only the bench scenarios can show the exact match latency and the repeat interval for both clock codes. The same applies to the prohibited codes, the suppression of stalled matches, masking, pin gating and the write-1 rule of the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_FAST = 2'd1,
        ST_SLOW = 2'd2
    } run_state_t;

    localparam int CB_OUT  = 7;
    localparam int CB_OVF  = 6;
    localparam int CB_CAPH = 5;
    localparam int CB_CAPL = 4;
    localparam int CB_INV  = 3;
    localparam int CB_SELH = 2;
    localparam int CB_SELL = 1;
    localparam int CB_OE   = 0;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CMP  = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;
endpackage

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] clk_sel,
    input  logic [1:0] cap_edge,
    output run_state_t state,
    output logic       run,
    output logic       slow,
    output logic       restart
);
    run_state_t next_state;

    always_comb begin
        next_state = ST_HALT;
        if (cap_edge != 2'b00) begin
            unique case (clk_sel)
                2'b00:   next_state = ST_FAST;
                2'b01:   next_state = ST_SLOW;
                default: next_state = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HALT;
        else     state <= next_state;
    end

    always_comb begin
        run     = 1'b0;
        slow    = 1'b0;
        restart = (next_state != state);
        unique case (state)
            ST_HALT: begin run = 1'b0; slow = 1'b0; end
            ST_FAST: begin run = 1'b1; slow = 1'b0; end
            ST_SLOW: begin run = 1'b1; slow = 1'b1; end
            default: begin run = 1'b0; slow = 1'b0; end
        endcase
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int FAST_LOG2 = 2,
    parameter int SLOW_LOG2 = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow,
    input  logic restart,
    output logic tick
);
    localparam int PW = SLOW_LOG2;
    localparam logic [PW-1:0] LAST_FAST = PW'((1 << FAST_LOG2) - 1);
    localparam logic [PW-1:0] LAST_SLOW = PW'((1 << SLOW_LOG2) - 1);

    logic [PW-1:0] pre;
    logic [PW-1:0] last;

    assign last = slow ? LAST_SLOW : LAST_FAST;
    assign tick = run && !restart && (pre == last);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) pre <= '0;
        else if (tick)              pre <= '0;
        else                        pre <= pre + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    input  run_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic             match_evt,
    output logic             wrap_evt,
    output logic             irq_q
);
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt   = cnt + 1'b1;
    assign match_evt = tick && (cnt_nxt == cmp);
    assign wrap_evt  = tick && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            irq_q <= 1'b0;
        end else begin
            if (tick) cnt <= cnt_nxt;
            irq_q <= match_evt;
        end
    end

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> cnt == $past(cnt) + 1'b1);
    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_HALT |=> cnt == $past(cnt));
    // R5
    irq_value_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> cnt == $past(cmp));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic             match_evt,
    input  logic             wrap_evt,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] cmp,
    output logic [1:0]       clk_sel,
    output logic [1:0]       cap_edge,
    output logic             out_data,
    output logic             ovf,
    output logic             pin_en
);
    logic inv_en;
    logic ctrl_wr;
    logic [7:0] ctrl_rd;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp      <= '0;
            clk_sel  <= 2'b00;
            cap_edge <= 2'b00;
            inv_en   <= 1'b0;
            pin_en   <= 1'b0;
            out_data <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            if (wr_en && addr == A_CMP) cmp <= wr_data;
            if (ctrl_wr) begin
                clk_sel  <= wr_data[CB_SELH:CB_SELL];
                cap_edge <= wr_data[CB_CAPH:CB_CAPL];
                inv_en   <= wr_data[CB_INV];
                pin_en   <= wr_data[CB_OE];
                out_data <= wr_data[CB_OUT];
            end else if (match_evt && inv_en) begin
                out_data <= ~out_data;
            end
            if (wrap_evt)                       ovf <= 1'b1;
            else if (ctrl_wr && !wr_data[CB_OVF]) ovf <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd = {out_data, ovf, cap_edge, inv_en, clk_sel, pin_en};
        rd_data = '0;
        unique case (addr)
            A_CTRL:  rd_data[7:0] = ctrl_rd;
            A_CMP:   rd_data = cmp;
            A_CNT:   rd_data = cnt;
            default: rd_data = '0;
        endcase
    end

    // R7
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        (match_evt && inv_en && !ctrl_wr) |=> out_data != $past(out_data));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(ctrl_wr && !wr_data[CB_OVF])) |=> ovf);
endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int FAST_LOG2 = 2,
    parameter int SLOW_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_mask,
    output logic             irq,
    output logic             tmr_out,
    output logic             ovf_flag
);
    run_state_t       state;
    logic             run, slow, restart, tick;
    logic [CNT_W-1:0] cnt, cmp;
    logic             match_evt, wrap_evt, irq_q;
    logic [1:0]       clk_sel, cap_edge;
    logic             out_data, ovf, pin_en;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .cnt(cnt), .match_evt(match_evt), .wrap_evt(wrap_evt),
        .rd_data(rd_data), .cmp(cmp), .clk_sel(clk_sel), .cap_edge(cap_edge),
        .out_data(out_data), .ovf(ovf), .pin_en(pin_en)
    );

    tmr_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .cap_edge(cap_edge),
        .state(state), .run(run), .slow(slow), .restart(restart)
    );

    tmr_prescaler #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
        .clk(clk), .rst(rst), .run(run), .slow(slow), .restart(restart),
        .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cmp(cmp), .state(state),
        .cnt(cnt), .match_evt(match_evt), .wrap_evt(wrap_evt), .irq_q(irq_q)
    );

    assign irq      = irq_q && !irq_mask;
    assign tmr_out  = pin_en && out_data;
    assign ovf_flag = ovf;
endmodule

// File: tb/cmp_interval_timer_bench.sv
module cmp_interval_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NV = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic irq_mask = 1'b0;
    logic irq, tmr_out, ovf_flag;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_interval_timer #(.CNT_W(W)) u_cmp_interval_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_mask(irq_mask), .irq(irq),
        .tmr_out(tmr_out), .ovf_flag(ovf_flag)
    );

    // ctrl, compare, expected edges to irq (0 = none within 400), expected pin
    localparam logic [31:0] VEC [NV] = '{
        {8'h19, 8'd5, 12'd21,   4'd1},  // R2 fast, invert, pin on
        {8'h1B, 8'd3, 12'd193,  4'd1},  // R2 slow
        {8'h11, 8'd1, 12'd5,    4'd0},  // R7 no inversion
        {8'h18, 8'd2, 12'd9,    4'd0},  // R8 pin disabled
        {8'h19, 8'd0, 12'd1025, 4'd1},  // R5 compare 0 matches on wrap
        {8'h1D, 8'd2, 12'd0,    4'd0},  // R3 prohibited clock code 10
        {8'h09, 8'd2, 12'd0,    4'd0}   // R4 capture field 00
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // edges counted after the write edge until irq is seen, 0 if none
    task automatic wait_irq(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            #1;
            if (irq) begin n = i; break; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 count halted", v, 0);
        chk({irq, tmr_out, ovf_flag} == 3'b000, "R1 outputs", {irq, tmr_out, ovf_flag}, 0);

        // table of vectors
        for (int k = 0; k < NV; k++) begin
            int lim;
            do_reset();
            wr(2'd1, VEC[k][23:16]);
            wr(2'd0, VEC[k][31:24]);
            lim = (VEC[k][15:4] == 0) ? 400 : int'(VEC[k][15:4]) + 2;
            wait_irq(lim, n);
            chk(n == int'(VEC[k][15:4]), "R2/R3/R4/R5 vector irq edge", n, int'(VEC[k][15:4]));
            chk(tmr_out == VEC[k][0], "R7/R8 vector pin", tmr_out, VEC[k][0]);
            if (n != 0) begin
                @(posedge clk); #1;
                chk(irq == 1'b0, "R5 one-cycle pulse", irq, 0);
            end else begin
                rd(2'd2, v); chk(v == 0, "R3 held count", v, 0);
            end
        end

        // R5/R9 repeat interval and overflow
        do_reset();
        wr(2'd1, 8'd5);
        wr(2'd0, 8'h19);
        wait_irq(30, n);
        chk(n == 21, "R5 first match", n, 21);
        rd(2'd0, v); chk(v[6] == 1'b0, "R9 no overflow yet", v[6], 0);
        wait_irq(1100, n);
        chk(n == 1024, "R5 repeat interval", n, 1024);
        chk(tmr_out == 1'b0, "R7 second toggle", tmr_out, 0);
        rd(2'd2, v); chk(v == 5, "R5 count kept running", v, 5);
        chk(ovf_flag == 1'b1, "R9 overflow set", ovf_flag, 1);
        wr(2'd0, 8'h59);
        chk(ovf_flag == 1'b1, "R9 write 1 no effect", ovf_flag, 1);
        wr(2'd0, 8'h19);
        chk(ovf_flag == 1'b0, "R9 write 0 clears", ovf_flag, 0);
        wr(2'd0, 8'h59);
        rd(2'd0, v); chk(v[6] == 1'b0, "R9 write 1 does not set", v[6], 0);

        // R10 mask
        do_reset();
        irq_mask = 1'b1;
        wr(2'd1, 8'd5);
        wr(2'd0, 8'h19);
        wait_irq(40, n);
        chk(n == 0, "R10 masked irq", n, 0);
        chk(tmr_out == 1'b1, "R10 toggle unaffected", tmr_out, 1);
        rd(2'd2, v); chk(v > 5, "R10 counting unaffected", v, 6);
        irq_mask = 1'b0;

        // R6 stall on compare value, then compare write equal to held count
        do_reset();
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h19);
        wait_irq(20, n);
        chk(n == 9, "R6 match before stall", n, 9);
        wr(2'd0, 8'h1F);
        wait_irq(60, n);
        chk(n == 0, "R6 stalled no refire", n, 0);
        rd(2'd2, v); chk(v == 2, "R6 held at compare", v, 2);
        wr(2'd1, 8'd2);
        wait_irq(20, n);
        chk(n == 0, "R6 compare write no fire", n, 0);
        wr(2'd0, 8'h19);
        wait_irq(100, n);
        chk(n == 0, "R6 resume no refire", n, 0);

        // R11 register map
        wr(2'd1, 8'hA7);
        rd(2'd1, v); chk(v == 8'hA7, "R11 compare readback", v, 8'hA7);
        rd(2'd3, v); chk(v == 0, "R11 address 3 reads 0", v, 0);
        rd(2'd0, v); chk(v[5:0] == 6'h19, "R11 ctrl readback", v[5:0], 6'h19);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule